// File: doc/BRIEF.md
# Address Range Match Qualifier

This block decides, one lookup at a time, whether an instruction or data address falls inside a set of up to four programmed address windows. The result is a single qualifier bit that event-counting logic uses to count only the events tied to addresses in those windows. It can also count only the events that fall outside them. Each window is described by a pair of configuration registers. Eight such registers can be written through a simple write port.

A pair is read in one of two ways. In mask mode, the first register is a base and the second is a bitmask. An address matches when it agrees with the base on every bit where the mask is one. This covers an aligned power-of-two block, which may be larger than the span actually wanted. In fine mode, the two registers are explicit start and end bounds. Both bounds lie in one 4 KB page and are resolved to 16-byte bundles.

Fine mode is a single global switch that governs every pair for code lookups. Data lookups always use mask mode. Code lookups are also gated by a per-pair privilege mask, while data lookups ignore privilege. A global invert bit turns the qualifier into an "outside all windows" indication. The qualifier is registered and appears one cycle after the lookup.

Top module: `addr_range_qual`

## Requirements
- R1: Configuration register k (k = 0..7, selected by `cfg_wr_idx`) is written with `cfg_wr_data` on a clock edge where `cfg_wr_en` is high. Register 2p is the base (mask mode) or start (fine mode) of pair p. Register 2p+1 is the mask (mask mode) or end (fine mode) of pair p. All registers reset to zero.
- R2: In mask mode, pair p matches an address A when ((A xor base) and mask) is zero.
- R3: In fine mode, pair p matches a code address A when A[31:12] equals start[31:12] and start[11:4] <= A[11:4] < end[11:4]. The start bound is inclusive and the end bound is exclusive. Bits 3:0 of every operand are ignored.
- R4: `fine_mode` applies to all pairs together, and only for lookups with `addr_is_code` = 1. Lookups with `addr_is_code` = 0 always use mask mode.
- R5: A pair whose bit in `pair_en` is 0 never matches. Before inversion, the qualifier is the OR of the matches of all enabled pairs.
- R6: For a code lookup, pair p can match only when bit `addr_pl` of its 4-bit privilege mask `pair_plm[4p+3:4p]` is 1. Data lookups ignore the privilege mask.
- R7: When `invert` is 1, the qualifier is 1 exactly when no enabled pair matches.
- R8: `qual_vld` follows `addr_vld` with one cycle of latency. `qual` carries the result of the previous cycle's lookup, and is 0 whenever `qual_vld` is 0. Both outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_idx | input | 3 | Register index to write |
| cfg_wr_data | input | 32 | Register write value |
| pair_en | input | 4 | Per-pair enable |
| pair_plm | input | 16 | Per-pair privilege masks, 4 bits per pair |
| fine_mode | input | 1 | Global fine-bounds mode for code lookups |
| invert | input | 1 | Qualify addresses outside all windows |
| addr_vld | input | 1 | Lookup request |
| addr | input | 32 | Lookup address |
| addr_pl | input | 2 | Privilege level of the lookup |
| addr_is_code | input | 1 | 1 = code address, 0 = data address |
| qual_vld | output | 1 | Result valid, one cycle after request |
| qual | output | 1 | Qualifier result |

## Verification
Two functions can fall in the same cycle. One is the choice between the mask compare and the fine-bounds compare, which depends on the lookup kind. The other is the privilege gating that applies only to code lookups. The bench provokes this overlap with fine mode switched on and a restricted privilege mask in force. It issues code and data lookups against the same pair registers and judges each result against the outcome worked out separately for mask and bounds interpretation. The invert bit is also exercised on both matching and non-matching addresses, and the result is checked against the inverted OR of the enabled pairs.

// File: rtl/addr_range_qual_pkg.sv
package addr_range_qual_pkg;

    // Role of a configuration register inside its pair
    typedef enum logic {
        ROLE_LOW  = 1'b0,
        ROLE_HIGH = 1'b1
    } reg_role_e;

    localparam int unsigned BUNDLE_LSB = 4;
    localparam int unsigned PAGE_LSB   = 12;

    function automatic reg_role_e role_of(input logic idx_lsb);
        return reg_role_e'(idx_lsb);
    endfunction

endpackage

// File: rtl/arq_cfg_regs.sv
module arq_cfg_regs #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned NUM_PAIRS = 4,
    localparam int unsigned NUM_REGS = 2 * NUM_PAIRS,
    localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [ADDR_W-1:0]                 wr_data,
    output logic [NUM_PAIRS-1:0][ADDR_W-1:0]  low_q,
    output logic [NUM_PAIRS-1:0][ADDR_W-1:0]  high_q
);
    import addr_range_qual_pkg::*;

    logic [NUM_REGS-1:0][ADDR_W-1:0] regs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (wr_en) begin
            regs_q[wr_idx] <= wr_data;
        end
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair_out
        assign low_q[p]  = regs_q[2*p + int'(ROLE_LOW)];
        assign high_q[p] = regs_q[2*p + int'(ROLE_HIGH)];
    end

    // R1: a write lands in the addressed register
    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> regs_q[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/arq_pair_match.sv
module arq_pair_match #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned PLM_W  = 4,
    localparam int unsigned PL_W  = $clog2(PLM_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] low_reg,
    input  logic [ADDR_W-1:0] high_reg,
    input  logic              enable,
    input  logic [PLM_W-1:0]  plm,
    input  logic              fine_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PL_W-1:0]   pl,
    input  logic              is_code,
    output logic              hit
);
    import addr_range_qual_pkg::*;

    logic mask_hit;
    logic fine_hit;
    logic same_page;
    logic above_start;
    logic below_end;
    logic priv_ok;
    logic use_fine;

    assign mask_hit = ((addr ^ low_reg) & high_reg) == '0;

    assign same_page   = addr[ADDR_W-1:PAGE_LSB] == low_reg[ADDR_W-1:PAGE_LSB];
    assign above_start = addr[PAGE_LSB-1:BUNDLE_LSB] >= low_reg[PAGE_LSB-1:BUNDLE_LSB];
    assign below_end   = addr[PAGE_LSB-1:BUNDLE_LSB] <  high_reg[PAGE_LSB-1:BUNDLE_LSB];
    assign fine_hit    = same_page && above_start && below_end;

    assign use_fine = fine_mode && is_code;
    assign priv_ok  = !is_code || plm[pl];

    always_comb begin
        if (!enable || !priv_ok) begin
            hit = 1'b0;
        end else if (use_fine) begin
            hit = fine_hit;
        end else begin
            hit = mask_hit;
        end
    end

    // R5: a disabled pair stays silent
    a_r5_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !hit);

    // R3: a fine-mode code hit lies in the start register's page
    a_r3_fine_same_page: assert property (@(posedge clk) disable iff (!rst_n)
        (fine_mode && is_code && hit) |-> addr[ADDR_W-1:PAGE_LSB] == low_reg[ADDR_W-1:PAGE_LSB]);

    // R6: a code hit needs the privilege bit
    a_r6_priv_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (is_code && hit) |-> plm[pl]);

endmodule

// File: rtl/addr_range_qual.sv
module addr_range_qual #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned NUM_PAIRS = 4,
    parameter int unsigned PLM_W     = 4,
    localparam int unsigned NUM_REGS = 2 * NUM_PAIRS,
    localparam int unsigned IDX_W    = $clog2(NUM_REGS),
    localparam int unsigned PL_W     = $clog2(PLM_W)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_wr_en,
    input  logic [IDX_W-1:0]           cfg_wr_idx,
    input  logic [ADDR_W-1:0]          cfg_wr_data,
    input  logic [NUM_PAIRS-1:0]       pair_en,
    input  logic [NUM_PAIRS*PLM_W-1:0] pair_plm,
    input  logic                       fine_mode,
    input  logic                       invert,
    input  logic                       addr_vld,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [PL_W-1:0]            addr_pl,
    input  logic                       addr_is_code,
    output logic                       qual_vld,
    output logic                       qual
);
    logic [NUM_PAIRS-1:0][ADDR_W-1:0] low_q;
    logic [NUM_PAIRS-1:0][ADDR_W-1:0] high_q;
    logic [NUM_PAIRS-1:0]             pair_hit;
    logic                             any_hit;

    arq_cfg_regs #(
        .ADDR_W    (ADDR_W),
        .NUM_PAIRS (NUM_PAIRS)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_idx  (cfg_wr_idx),
        .wr_data (cfg_wr_data),
        .low_q   (low_q),
        .high_q  (high_q)
    );

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        arq_pair_match #(
            .ADDR_W (ADDR_W),
            .PLM_W  (PLM_W)
        ) u_match (
            .clk       (clk),
            .rst_n     (rst_n),
            .low_reg   (low_q[p]),
            .high_reg  (high_q[p]),
            .enable    (pair_en[p]),
            .plm       (pair_plm[p*PLM_W +: PLM_W]),
            .fine_mode (fine_mode),
            .addr      (addr),
            .pl        (addr_pl),
            .is_code   (addr_is_code),
            .hit       (pair_hit[p])
        );
    end

    assign any_hit = |pair_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qual_vld <= 1'b0;
            qual     <= 1'b0;
        end else begin
            qual_vld <= addr_vld;
            qual     <= addr_vld & (any_hit ^ invert);
        end
    end

    // R8: one-cycle valid latency
    a_r8_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        qual_vld == $past(addr_vld));

    // R8: no qualifier without valid
    a_r8_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !qual_vld |-> !qual);

    // R7: with every pair disabled the result is just the invert bit
    a_r7_none_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(addr_vld) && $past(pair_en) == '0) |-> qual == $past(invert));

endmodule

// File: tb/addr_range_qual_tb_top.sv
`timescale 1ns/1ps
module addr_range_qual_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_wr_idx = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [3:0]  pair_en = '0;
    logic [15:0] pair_plm = '0;
    logic        fine_mode = 1'b0;
    logic        invert = 1'b0;
    logic        addr_vld = 1'b0;
    logic [31:0] addr = '0;
    logic [1:0]  addr_pl = '0;
    logic        addr_is_code = 1'b0;
    logic        qual_vld;
    logic        qual;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    addr_range_qual dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_wr_idx   (cfg_wr_idx),
        .cfg_wr_data  (cfg_wr_data),
        .pair_en      (pair_en),
        .pair_plm     (pair_plm),
        .fine_mode    (fine_mode),
        .invert       (invert),
        .addr_vld     (addr_vld),
        .addr         (addr),
        .addr_pl      (addr_pl),
        .addr_is_code (addr_is_code),
        .qual_vld     (qual_vld),
        .qual         (qual)
    );

    typedef struct packed {
        logic [31:0] a;
        logic        code;
        logic [1:0]  pl;
        logic        exp;
    } vec_t;

    // Mask-mode set: pair0 0x1000/0xFFFFF000, pair1 0x80000000/0xFFFFFF00,
    // pair2 0/0 (disabled), pair3 0x40000000/0xC0000000
    localparam vec_t [0:11] VECS = '{
        '{32'h0000_1000, 1'b0, 2'd0, 1'b1},
        '{32'h0000_1FFC, 1'b0, 2'd0, 1'b1},
        '{32'h0000_2000, 1'b0, 2'd0, 1'b0},
        '{32'h0000_0FFF, 1'b0, 2'd0, 1'b0},
        '{32'h8000_00FF, 1'b0, 2'd0, 1'b1},
        '{32'h8000_0100, 1'b0, 2'd0, 1'b0},
        '{32'h4000_0000, 1'b0, 2'd0, 1'b1},
        '{32'h7FFF_FFF0, 1'b0, 2'd0, 1'b1},
        '{32'h8000_0000, 1'b0, 2'd0, 1'b1},
        '{32'hC000_0000, 1'b0, 2'd0, 1'b0},
        '{32'h0000_0000, 1'b0, 2'd0, 1'b0},
        '{32'h0000_1234, 1'b1, 2'd3, 1'b1}
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_idx  = 3'(idx);
        cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
    endtask

    // drive one lookup, sample one cycle later, check qual and qual_vld
    task automatic look(input string req, input logic [31:0] a, input logic code,
                        input logic [1:0] pl, input logic exp);
        @(negedge clk);
        addr_vld     = 1'b1;
        addr         = a;
        addr_is_code = code;
        addr_pl      = pl;
        @(negedge clk);
        addr_vld     = 1'b0;
        check(req, qual, exp);
        if (qual_vld !== 1'b1) begin
            checks++;
            fails++;
            $display("FAIL R8: qual_vld got %0b expected 1", qual_vld);
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 reset qual_vld", qual_vld, 1'b0);
        check("R8 reset qual", qual, 1'b0);
        rst_n = 1'b1;

        // R1: program the eight registers
        wr(0, 32'h0000_1000); wr(1, 32'hFFFF_F000);
        wr(2, 32'h8000_0000); wr(3, 32'hFFFF_FF00);
        wr(4, 32'h0000_0000); wr(5, 32'h0000_0000);
        wr(6, 32'h4000_0000); wr(7, 32'hC000_0000);
        pair_en  = 4'b1011;
        pair_plm = 16'hFFFF;

        // R2 / R5: table walk
        foreach (VECS[i]) begin
            look("R2 table", VECS[i].a, VECS[i].code, VECS[i].pl, VECS[i].exp);
        end

        // R5: enabling pair2 (matches everything) turns the miss into a hit
        pair_en = 4'b1111;
        look("R5 enable pair2", 32'hC000_0000, 1'b0, 2'd0, 1'b1);
        pair_en = 4'b0000;
        look("R5 none enabled", 32'h0000_1000, 1'b0, 2'd0, 1'b0);
        pair_en = 4'b1011;

        // R7: invert
        invert = 1'b1;
        look("R7 invert outside", 32'h0000_2000, 1'b0, 2'd0, 1'b1);
        look("R7 invert inside", 32'h0000_1000, 1'b0, 2'd0, 1'b0);
        invert = 1'b0;

        // R6: pair0 restricted to level 0
        pair_plm = 16'hFFF1;
        look("R6 code pl3 blocked", 32'h0000_1000, 1'b1, 2'd3, 1'b0);
        look("R6 code pl0 allowed", 32'h0000_1000, 1'b1, 2'd0, 1'b1);
        look("R6 data ignores plm", 32'h0000_1000, 1'b0, 2'd3, 1'b1);

        // R3 / R4: fine mode, pair0 start 0x5040 end 0x50A0
        wr(0, 32'h0000_5040); wr(1, 32'h0000_50A0);
        fine_mode = 1'b1;
        look("R3 fine start inclusive", 32'h0000_5040, 1'b1, 2'd0, 1'b1);
        look("R3 fine low bits ignored", 32'h0000_5048, 1'b1, 2'd0, 1'b1);
        look("R3 fine last bundle", 32'h0000_509F, 1'b1, 2'd0, 1'b1);
        look("R3 fine end exclusive", 32'h0000_50A0, 1'b1, 2'd0, 1'b0);
        look("R3 fine below start", 32'h0000_503F, 1'b1, 2'd0, 1'b0);
        look("R3 fine other page", 32'h0000_6040, 1'b1, 2'd0, 1'b0);
        look("R3 fine pair1", 32'h8000_0EF0, 1'b1, 2'd0, 1'b1);
        look("R4 code uses bounds", 32'h0000_7000, 1'b1, 2'd0, 1'b0);
        look("R4 data uses mask", 32'h0000_7000, 1'b0, 2'd0, 1'b1);
        look("R4 R6 fine blocked by plm", 32'h0000_5040, 1'b1, 2'd2, 1'b0);
        fine_mode = 1'b0;

        // R8: idle cycle after a hit
        look("R8 hit before idle", 32'h0000_7000, 1'b0, 2'd0, 1'b1);
        @(negedge clk);
        check("R8 idle qual_vld", qual_vld, 1'b0);
        check("R8 idle qual", qual, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule